// File: doc/BRIEF.md
# Residue generator modulo 2^W-1

The block reduces an unsigned binary word of 3W bits to its residue modulo 2^W-1, a W-bit value. It is the front end of a residue-number datapath: each operand enters in plain binary and leaves as one residue digit for the 2^W-1 channel. Since 2^W is congruent to 1 modulo 2^W-1, the word is cut into three W-bit slices. The slices are added modulo 2^W-1, with no division and no table.

The slices feed a carry-save layer whose top carry wraps around into bit 0. The sum and carry vectors then go to a ripple adder whose lowest cell adds a constant one. A decrementer fires when that adder gives no carry out. Its top cell is a bare XOR. A last fold maps the one value that is still all ones to zero, so the output is always canonical. A parameter chooses between a purely combinational output and an output register for timing closure.

Top module: `mersenne_residue_gen`

## Requirements
- R1: For every input word X of 3W bits, residue_o equals X mod (2^W-1). The low slice is bits W-1..0, the middle slice is bits 2W-1..W and the high slice is bits 3W-1..2W.
- R2: residue_o always lies in 0..2^W-2 and is never all ones.
- R3: Inputs that are whole multiples of 2^W-1 give 0. This includes the word 2^W-1, whose low slice is all ones, and the word 2^(3W)-1, whose bits are all ones.
- R4: The all-zero word gives 0, and any word below 2^W-1 gives itself.
- R5: With OUT_MODE = OUT_REG, residue_o changes only on a rising clk edge. After the edge it shows the residue of the word that was present at that edge. With OUT_MODE = OUT_COMB, residue_o follows word_i with no clock.
- R6: With OUT_MODE = OUT_REG, a rising clk edge with rst high sets residue_o to 0. With OUT_MODE = OUT_COMB, rst has no effect on residue_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| word_i | input | 3*W | Unsigned binary word to reduce |
| residue_o | output | W | Canonical residue modulo 2^W-1 |

## Verification
The assertions check the following on every clock edge:
- The output is never the all-ones pattern.
- The incremented adder never produces zero without a carry out, so the decrementer never underflows.
- The decrementer leaves its operand unchanged whenever the adder carried out.
- A reset edge in registered mode leaves a zero output.

Only the bench's scenarios can show that the value equals X mod (2^W-1). It sweeps every word for W = 4, drives random and corner words for W = 6 and W = 8, and checks the timing of the registered output and the reset behaviour.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_stage_e;

    localparam int unsigned MIN_WIDTH = 3;
    localparam int unsigned SLICES    = 3;

    function automatic int unsigned word_bits(input int unsigned w);
        return SLICES * w;
    endfunction

endpackage

// File: rtl/mrg_csa.sv
module mrg_csa #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] mid_i,
    input  logic [W-1:0] hi_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    logic [W-1:0] maj;

    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum_o[i] = lo_i[i] ^ mid_i[i] ^ hi_i[i];
        assign maj[i]   = (lo_i[i] & mid_i[i]) | (lo_i[i] & hi_i[i]) | (mid_i[i] & hi_i[i]);
        if (i == 0) begin : g_wrap
            assign carry_o[0] = maj[W-1];
        end else begin : g_shift
            assign carry_o[i] = maj[i-1];
        end
    end

    // R4: zero slices give zero sum and carry vectors
    assert_zero_in_zero_out_R4: assert property (@(posedge clk) disable iff (rst)
        ((lo_i == '0) && (mid_i == '0) && (hi_i == '0)) |-> ((sum_o == '0) && (carry_o == '0)));

endmodule

// File: rtl/mrg_inc_adder.sv
module mrg_inc_adder #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] chain;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_plus_one
            assign sum_o[0] = ~(op_a_i[0] ^ op_b_i[0]);
            assign chain[1] = op_a_i[0] | op_b_i[0];
        end else begin : g_full
            assign sum_o[i]   = op_a_i[i] ^ op_b_i[i] ^ chain[i];
            assign chain[i+1] = (op_a_i[i] & op_b_i[i]) | (chain[i] & (op_a_i[i] ^ op_b_i[i]));
        end
    end

    assign chain[0] = 1'b1;
    assign cout_o   = chain[W];

    // R2: without a carry out the incremented sum is at least one, so the decrement cannot underflow
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
        (!cout_o) |-> (sum_o != '0));

endmodule

// File: rtl/mrg_fold_decr.sv
module mrg_fold_decr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] val_i,
    input  logic         cout_i,
    output logic [W-1:0] res_o
);

    logic [W-1:0] borrow;
    logic [W-1:0] dec;

    assign borrow[0] = ~cout_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dec[i] = val_i[i] ^ borrow[i];
        if (i < W - 1) begin : g_chain
            assign borrow[i+1] = borrow[i] & ~val_i[i];
        end
    end

    assign res_o = (&dec) ? '0 : dec;

    // R1: when the adder carried out, the value passes unchanged unless it is the all-ones pattern
    assert_pass_on_carry_R1: assert property (@(posedge clk) disable iff (rst)
        (cout_i && (val_i != '1)) |-> (res_o == val_i));

    // R3: an all-ones value after a carry out folds to zero
    assert_fold_ones_R3: assert property (@(posedge clk) disable iff (rst)
        (cout_i && (val_i == '1)) |-> (res_o == '0));

endmodule

// File: rtl/mersenne_residue_gen.sv
module mersenne_residue_gen
    import mrg_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter out_stage_e  OUT_MODE = OUT_COMB
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [word_bits(W)-1:0] word_i,
    output logic [W-1:0]            residue_o
);

    localparam int unsigned XW = word_bits(W);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] mid;
        logic [W-1:0] lo;
    } slices_t;

    typedef struct packed {
        logic [W-1:0] sum;
        logic [W-1:0] carry;
    } redundant_t;

    slices_t      parts;
    redundant_t   red;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] res_comb;

    assign parts = slices_t'(word_i[XW-1:0]);

    mrg_csa #(.W(W)) u_csa (
        .clk     (clk),
        .rst     (rst),
        .lo_i    (parts.lo),
        .mid_i   (parts.mid),
        .hi_i    (parts.hi),
        .sum_o   (red.sum),
        .carry_o (red.carry)
    );

    mrg_inc_adder #(.W(W)) u_add (
        .clk    (clk),
        .rst    (rst),
        .op_a_i (red.sum),
        .op_b_i (red.carry),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    mrg_fold_decr #(.W(W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .val_i  (add_sum),
        .cout_i (add_cout),
        .res_o  (res_comb)
    );

    if (OUT_MODE == OUT_REG) begin : g_reg
        logic [W-1:0] res_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
            end else begin
                res_q <= res_comb;
            end
        end
        assign residue_o = res_q;

        // R6: a reset edge leaves a zero output
        assert_reset_clears_R6: assert property (@(posedge clk)
            rst |=> (residue_o == '0));
    end else begin : g_comb
        assign residue_o = res_comb;
    end

    // R2: the output is canonical
    assert_canonical_R2: assert property (@(posedge clk) disable iff (rst)
        residue_o != '1);

endmodule

// File: tb/mersenne_residue_gen_test.sv
`timescale 1ns/1ps
module mersenne_residue_gen_test;
    import mrg_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] w4  = '0;
    logic [17:0] w6  = '0;
    logic [23:0] w8  = '0;
    logic [3:0]  r4;
    logic [5:0]  r6;
    logic [7:0]  r8;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mersenne_residue_gen #(.W(4), .OUT_MODE(OUT_COMB)) uut (
        .clk(clk), .rst(rst), .word_i(w4), .residue_o(r4));
    mersenne_residue_gen #(.W(6), .OUT_MODE(OUT_COMB)) uut_w6 (
        .clk(clk), .rst(rst), .word_i(w6), .residue_o(r6));
    mersenne_residue_gen #(.W(8), .OUT_MODE(OUT_REG)) uut_w8 (
        .clk(clk), .rst(rst), .word_i(w8), .residue_o(r8));

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_mod(input longint x, input int w);
        return x % ((longint'(1) << w) - 1);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic step8(input logic [23:0] x);
        @(negedge clk);
        w8 = x;
        @(posedge clk);
        @(negedge clk);
        check("R5 registered residue", r8, ref_mod(x, 8));
        check("R2 registered canonical", (r8 == 8'hFF), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset clears registered output", r8, 0);
        w4 = 12'd5;
        #1;
        check("R6 comb output ignores reset", r4, 5);
        @(negedge clk);
        rst = 1'b0;

        // W=4 exhaustive sweep
        for (int x = 0; x < 4096; x++) begin
            w4 = 12'(x);
            #1;
            check("R1 W4 sweep", r4, ref_mod(x, 4));
            check("R2 W4 canonical", (r4 == 4'hF), 0);
        end
        w4 = 12'd0;     #1; check("R4 W4 zero", r4, 0);
        w4 = 12'd9;     #1; check("R4 W4 small word", r4, 9);
        w4 = 12'd15;    #1; check("R3 W4 low slice ones", r4, 0);
        w4 = 12'hFFF;   #1; check("R3 W4 all ones", r4, 0);
        w4 = 12'd30;    #1; check("R3 W4 multiple", r4, 0);

        // W=6 random and corners
        for (int k = 0; k < 3000; k++) begin
            logic [17:0] v;
            v  = 18'($urandom);
            w6 = v;
            #1;
            check("R1 W6 random", r6, ref_mod(longint'(v), 6));
        end
        w6 = 18'd63;      #1; check("R3 W6 low slice ones", r6, 0);
        w6 = 18'h3FFFF;   #1; check("R3 W6 all ones", r6, 0);
        w6 = 18'd0;       #1; check("R4 W6 zero", r6, 0);
        w6 = 18'd62;      #1; check("R4 W6 top canonical", r6, 62);
        w6 = 18'd54425;   #1; check("R1 W6 sample", r6, ref_mod(54425, 6));

        // W=8 registered
        step8(24'd255);
        step8(24'hFFFFFF);
        step8(24'd0);
        step8(24'd254);
        for (int k = 0; k < 2000; k++) begin
            step8(24'($urandom));
        end
        // output holds between edges
        step8(24'd1000);
        @(negedge clk);
        w8 = 24'd77;
        #1;
        check("R5 holds until edge", r8, ref_mod(1000, 8));
        @(posedge clk);
        @(negedge clk);
        check("R5 updates on edge", r8, 77);
        // mid-run reset
        rst = 1'b1;
        w8  = 24'd300;
        @(posedge clk);
        @(negedge clk);
        check("R6 reset clears mid-run", r8, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 resumes after reset", r8, ref_mod(300, 8));

        finish_run();
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

endmodule